// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry Arithmetic Logic Unit

This block is a combinational integer ALU for a 32-bit datapath. It is built from a row of identical one-bit slices. Each slice can invert either operand bit. It then forms the AND, the OR and a full-adder sum of the two bits, and passes its carry to the next slice up. A small decoder turns a four-bit function select into the per-slice controls. These are the two inversion enables, the carry injected into bit 0, and the choice of which slice output becomes the result bit.

Subtraction inverts the B operand and injects a carry of one. Signed set-on-less-than reuses that subtraction. The top slice corrects its sum bit for signed overflow and returns it to the "less" input of bit 0, while every other bit reads zero. NOR is formed by inverting both operands and taking the AND. Two function codes both select the addition. The second is kept so that a pipeline controller can name the ripple-carry adder explicitly. The block also reports a zero flag and the carry out of the chain.

Top module: `alu_ripple32`

## Requirements
- R1: Function code 4'b0000 gives result = A & B.
- R2: Function code 4'b0001 gives result = A | B.
- R3: Function code 4'b1100 gives result = ~(A | B), with carry_out 0.
- R4: Function code 4'b0010 gives result = (A + B) mod 2^32, and carry_out is bit 32 of the unsigned sum.
- R5: Function code 4'b1010 selects the ripple-carry add path. For any operands, its result and carry_out equal those of code 4'b0010.
- R6: Function code 4'b0110 gives result = (A - B) mod 2^32, and carry_out = 1 exactly when A >= B as unsigned numbers (no borrow).
- R7: Function code 4'b0111 gives result 32'h1 when A < B as signed two's-complement numbers, and 32'h0 otherwise. This holds even when A - B overflows. Bits 31:1 are always zero, and carry_out follows the R6 rule.
- R8: zero_flag is 1 exactly when all 32 result bits are 0, for every function code.
- R9: carry_out is 0 for the logic codes 4'b0000, 4'b0001 and 4'b1100.
- R10: Every function code not listed above behaves as 4'b0000 (AND), with carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | Operand A |
| opd_b | input | 32 | Operand B |
| func_sel | input | 4 | Function select code |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry from the top slice for arithmetic codes, else 0 |

## Verification
The zero flag and the carry out can both be asserted in the same evaluation. The bench provokes this with an add of all-ones and one, and with a subtraction of a value from itself. Each of these wraps the chain to zero while a carry leaves the top slice. The set-on-less-than result likewise coincides with a carry decision. Operand pairs at the signed extremes, where A - B overflows, are driven to show that bit 0 follows the corrected sign and not the raw sum bit. Every vector is compared on each clock against a behavioural model in the bench that uses plain integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned FUNC_W = 4;

  // function select codes
  localparam logic [FUNC_W-1:0] FN_AND  = 4'b0000;
  localparam logic [FUNC_W-1:0] FN_OR   = 4'b0001;
  localparam logic [FUNC_W-1:0] FN_ADD  = 4'b0010;
  localparam logic [FUNC_W-1:0] FN_RADD = 4'b1010;
  localparam logic [FUNC_W-1:0] FN_SUB  = 4'b0110;
  localparam logic [FUNC_W-1:0] FN_SLT  = 4'b0111;
  localparam logic [FUNC_W-1:0] FN_NOR  = 4'b1100;

  // which slice output becomes the result bit
  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } pick_e;

  typedef struct packed {
    logic  inv_a;
    logic  inv_b;
    logic  carry0;
    logic  arith;
    pick_e pick;
  } slice_ctl_t;

endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import alu_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output slice_ctl_t        ctl_o
);

  always_comb begin
    // default: behave as AND, carry suppressed
    ctl_o = '{inv_a: 1'b0, inv_b: 1'b0, carry0: 1'b0, arith: 1'b0, pick: PICK_AND};
    unique case (func_i)
      FN_OR:   ctl_o.pick = PICK_OR;
      FN_ADD,
      FN_RADD: begin
        ctl_o.pick  = PICK_SUM;
        ctl_o.arith = 1'b1;
      end
      FN_SUB: begin
        ctl_o.pick   = PICK_SUM;
        ctl_o.arith  = 1'b1;
        ctl_o.inv_b  = 1'b1;
        ctl_o.carry0 = 1'b1;
      end
      FN_SLT: begin
        ctl_o.pick   = PICK_LESS;
        ctl_o.arith  = 1'b1;
        ctl_o.inv_b  = 1'b1;
        ctl_o.carry0 = 1'b1;
      end
      FN_NOR: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.inv_b = 1'b1;
      end
      default: ctl_o.pick = PICK_AND;
    endcase
  end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic  a_i,
  input  logic  b_i,
  input  logic  inv_a_i,
  input  logic  inv_b_i,
  input  logic  c_i,
  input  logic  less_i,
  input  pick_e pick_i,
  output logic  res_o,
  output logic  c_o,
  output logic  set_o
);

  logic aa, bb, sum;

  always_comb begin
    aa  = a_i ^ inv_a_i;
    bb  = b_i ^ inv_b_i;
    sum = aa ^ bb ^ c_i;
    c_o = (aa & bb) | (c_i & (aa ^ bb));
    unique case (pick_i)
      PICK_AND:  res_o = aa & bb;
      PICK_OR:   res_o = aa | bb;
      PICK_SUM:  res_o = sum;
      PICK_LESS: res_o = less_i;
      default:   res_o = 1'b0;
    endcase
  end

  generate
    if (IS_TOP) begin : g_top
      // signed sign of the difference: raw sign corrected by overflow
      assign set_o = sum ^ (c_i ^ c_o);
    end else begin : g_mid
      assign set_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/alu_ripple32.sv
module alu_ripple32
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  opd_a,
  input  logic [WIDTH-1:0]  opd_b,
  input  logic [FUNC_W-1:0] func_sel,
  output logic [WIDTH-1:0]  result,
  output logic              zero_flag,
  output logic              carry_out
);

  localparam int unsigned TOP = WIDTH - 1;

  slice_ctl_t       ctl;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] set_vec;
  logic             slt_bit;

  alu_ctrl_dec u_dec (
    .func_i (func_sel),
    .ctl_o  (ctl)
  );

  assign chain[0] = ctl.carry0;
  // only the top slice drives a nonzero set bit
  assign slt_bit  = |set_vec;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_bit_cell #(.IS_TOP(i == TOP)) u_cell (
        .a_i     (opd_a[i]),
        .b_i     (opd_b[i]),
        .inv_a_i (ctl.inv_a),
        .inv_b_i (ctl.inv_b),
        .c_i     (chain[i]),
        .less_i  ((i == 0) ? slt_bit : 1'b0),
        .pick_i  (ctl.pick),
        .res_o   (result[i]),
        .c_o     (chain[i+1]),
        .set_o   (set_vec[i])
      );
    end
  endgenerate

  assign zero_flag = (result == '0);
  assign carry_out = ctl.arith & chain[WIDTH];

  always_comb begin
    if (func_sel == FN_AND) begin
      // R1
      and_chk: assert (result == (opd_a & opd_b)) else $error("and mismatch");
    end
    if (func_sel == FN_OR) begin
      // R2
      or_chk: assert (result == (opd_a | opd_b)) else $error("or mismatch");
    end
    if (func_sel == FN_NOR) begin
      // R3
      nor_chk: assert (result == ~(opd_a | opd_b) && !carry_out) else $error("nor mismatch");
    end
    if (func_sel == FN_ADD || func_sel == FN_RADD) begin
      // R4
      add_chk: assert ({carry_out, result} == ({1'b0, opd_a} + {1'b0, opd_b})) else $error("add mismatch");
    end
    if (func_sel == FN_SUB) begin
      // R6
      sub_chk: assert (result == opd_a - opd_b && carry_out == (opd_a >= opd_b)) else $error("sub mismatch");
    end
    if (func_sel == FN_SLT) begin
      // R7
      slt_chk: assert (result[WIDTH-1:1] == '0 && result[0] == ($signed(opd_a) < $signed(opd_b))) else $error("slt mismatch");
    end
  end

endmodule

// File: tb/alu_ripple32_tb.sv
module alu_ripple32_tb_top;

  localparam int W = 32;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  opd_a, opd_b, result;
  logic [3:0]    func_sel;
  logic          zero_flag, carry_out;
  bit            done;
  int            checks, errors;

  logic [W-1:0] qa[$];
  logic [W-1:0] qb[$];
  logic [3:0]   qf[$];

  alu_ripple32 dut_i (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .func_sel  (func_sel),
    .result    (result),
    .zero_flag (zero_flag),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string tag_of(input logic [3:0] f);
    case (f)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b1100: return "R3";
      4'b0010: return "R4";
      4'b1010: return "R5";
      4'b0110: return "R6";
      4'b0111: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic push(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    qf.push_back(f); qa.push_back(a); qb.push_back(b);
  endtask

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] r, output logic c);
    longint unsigned s;
    c = 1'b0;
    case (f)
      4'b0001: r = a | b;
      4'b1100: r = ~(a | b);
      4'b0010, 4'b1010: begin
        s = longint'(a) + longint'(b);
        r = s[W-1:0]; c = s[W];
      end
      4'b0110: begin r = a - b; c = (a >= b); end
      4'b0111: begin
        r = ($signed(a) < $signed(b)) ? 32'h1 : 32'h0;
        c = (a >= b);
      end
      default: r = a & b;
    endcase
  endtask

  initial begin
    logic [3:0] codes [8];
    codes = '{4'b0000, 4'b0001, 4'b1100, 4'b0010, 4'b1010, 4'b0110, 4'b0111, 4'b1111};
    rst_n = 1'b0; opd_a = '0; opd_b = '0; func_sel = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset-state inputs: AND of zeros (R8, R9)
    check("R8", {1'b0, zero_flag, W'(0)}, {1'b0, 1'b1, W'(0)});
    check("R9", {W'(0), carry_out}, '0);

    push(4'b0010, 32'hFFFF_FFFF, 32'h1);        // R4 zero and carry together
    push(4'b1010, 32'hFFFF_FFFF, 32'h1);        // R5
    push(4'b0110, 32'h1234_5678, 32'h1234_5678);// R6 zero with carry
    push(4'b0110, 32'h0, 32'h1);                // R6 borrow
    push(4'b0111, 32'h8000_0000, 32'h1);        // R7 overflow, true
    push(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);// R7 overflow, false
    push(4'b0111, 32'hFFFF_FFFF, 32'h0);        // R7 -1 < 0
    push(4'b0111, 32'h5, 32'h5);                // R7 equal
    push(4'b1100, 32'h0, 32'h0);                // R3 all ones
    push(4'b1100, 32'hFFFF_FFFF, 32'h0);        // R3 zero flag
    push(4'b0001, 32'hA5A5_0000, 32'h0000_5A5A);// R2
    push(4'b0000, 32'hF0F0_F0F0, 32'h0F0F_0F0F);// R1 zero
    push(4'b0101, 32'hFFFF_FFFF, 32'hFFFF_FFFF);// R10 unused code
    push(4'b1111, 32'hC3C3_C3C3, 32'hFFFF_0000);// R10
    push(4'b0010, 32'h8000_0000, 32'h8000_0000);// R4 carry, zero
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a;
      a = $urandom;
      push(codes[$urandom_range(0, 7)], a, (i % 5 == 0) ? a : W'($urandom));
    end

    while (qf.size() > 0) begin
      logic [3:0]   f;
      logic [W-1:0] a, b, er;
      logic         ec;
      string        t;
      @(posedge clk);
      f = qf.pop_front(); a = qa.pop_front(); b = qb.pop_front();
      opd_a = a; opd_b = b; func_sel = f;
      model(f, a, b, er, ec);
      t = tag_of(f);
      @(negedge clk);
      check(t, {1'b0, result}, {1'b0, er});
      check("R8", {W'(0), zero_flag}, {W'(0), (er == '0)});
      check((f == 4'b0000 || f == 4'b0001 || f == 4'b1100) ? "R9" : t,
            {W'(0), carry_out}, {W'(0), ec});
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule